// File: doc/BRIEF.md
# Packed-Subword Multiply-Add Unit

This unit carries out one integer multiply-add on narrow fields taken from two 32-bit source words. For each of the A and B operands, a selector picks either one of the four bytes or one of the two 16-bit halves. The chosen field is then zero-extended or sign-extended, as the operand's own signedness flag says. Operand B can instead be taken from a 16-bit immediate. The product A*B is added to a 32-bit accumulator C at full precision. An optional fixed right shift by 7 or by 15 supports fixed-point scaling. An optional clamp then keeps the value inside the 32-bit range, signed or unsigned. The lowest 32 bits are delivered as the result.

The decoded instruction fields arrive together with a valid/ready handshake. The work runs in two pipeline stages. The first stage forms the product. The second stage adds, shifts, clamps and holds the registered result, which is offered with its own valid/ready handshake. Each stage is a two-state machine. It is EMPTY after reset. It moves EMPTY->FULL when it takes an item. It stays FULL while it holds an item or when it hands one on and takes the next in the same cycle. It moves FULL->EMPTY when it hands its item on and nothing new arrives. A stall at the output backs up through both stages.

Two selector codes are special. A reserved code forces the result to zero. The 32-bit whole-word code is not supported: it produces zero and raises an error flag.

Top module: `subword_mac`

## Requirements
- R1: With `x_chunk`=0, an operand is byte `x_pos` (0..3) of its source, i.e. (src >> 8*pos) & 0xFF. It is sign-extended from bit 7 when the operand is signed and zero-extended otherwise.
- R2: With `x_chunk`=1, `x_type` 0 selects bits 15:0 and `x_type` 1 selects bits 31:16. The half is sign-extended from bit 15 when the operand is signed and zero-extended otherwise.
- R3: `x_type` 3 on a chunk-mode operand that is in use makes the result 0, with `out_err`=0, whatever the other fields are.
- R4: `x_type` 2 on a chunk-mode operand that is in use makes the result 0, with `out_err`=1.
- R5: When `b_from_reg`=0, B is `imm_b`, sign-extended if `b_signed` and zero-extended otherwise. `b_src`, `b_chunk`, `b_type` and `b_pos` then have no effect.
- R6: The result is signed when either `a_signed` or `b_signed` is set. C is sign-extended for a signed result and zero-extended for an unsigned one, and the value is A*B + C at full precision.
- R7: `shift_sel` 1 shifts the full-precision sum right by 7, and 2 shifts it by 15. Codes 0 and 3 do not shift. The shift is arithmetic for a signed result.
- R8: With `saturate`=1, the shifted value is clamped to [-2^31, 2^31-1] for a signed result and to [0, 2^32-1] for an unsigned one.
- R9: With `saturate`=0, `out_data` is the low 32 bits of the shifted value.
- R10: With `out_ready` held high, a result is valid in the second cycle after the input handshake. `in_ready` is low only while `out_valid`=1 and `out_ready`=0.
- R11: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_err` hold their values.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction fields valid |
| in_ready | output | 1 | Unit can take an instruction |
| a_src | input | 32 | Source word for operand A |
| b_src | input | 32 | Source word for operand B |
| c_acc | input | 32 | Accumulator C |
| imm_b | input | 16 | Immediate value for B |
| a_signed | input | 1 | A is signed |
| b_signed | input | 1 | B is signed |
| a_chunk | input | 1 | A uses half/word selection (1) or byte selection (0) |
| a_type | input | 2 | A half selector: 0 low, 1 high, 2 word (error), 3 reserved |
| a_pos | input | 2 | A byte position |
| b_chunk | input | 1 | B uses half/word selection |
| b_type | input | 2 | B half selector, coded like `a_type` |
| b_pos | input | 2 | B byte position |
| b_from_reg | input | 1 | B comes from `b_src` (1) or `imm_b` (0) |
| shift_sel | input | 2 | Post-shift: 0 none, 1 by 7, 2 by 15, 3 none |
| saturate | input | 1 | Clamp to the 32-bit range |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result |
| out_err | output | 1 | Unsupported whole-word selector used |

## Verification
A result becomes visible two clock edges after the edge at which `in_valid` and `in_ready` are both high. One edge loads the product stage, and the next loads the output register. The bench stamps every accepted instruction with the cycle count at that point. While the output is kept ready, it checks that the matching result first shows up exactly two cycles later. With random back-pressure, results are compared in order at the cycle where `out_valid` and `out_ready` are both high. Any cycle that follows a refused result must show the same valid result again. All inputs are driven, and all outputs sampled, at the falling edge.

// File: rtl/vmad_pkg.sv
package vmad_pkg;
    parameter int unsigned WORD = 32;
    localparam int unsigned HALF = WORD / 2;
    localparam int unsigned BYTE = 8;
    localparam int unsigned NPOS = WORD / BYTE;
    localparam int unsigned POSW = $clog2(NPOS);
    localparam int unsigned OPW  = HALF + 1;      // extended operand
    localparam int unsigned PRODW = 2 * OPW;      // signed product
    localparam int unsigned SUMW = PRODW + 1;     // product + accumulator

    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_WORD = 2'd2,
        SEL_RSVD = 2'd3
    } sub_sel_e;

    typedef enum logic [1:0] {
        SHR_NONE = 2'd0,
        SHR_7    = 2'd1,
        SHR_15   = 2'd2,
        SHR_ALT  = 2'd3
    } post_shr_e;

    typedef enum logic {
        STG_EMPTY = 1'b0,
        STG_FULL  = 1'b1
    } stage_st_e;

    typedef struct packed {
        logic signed [PRODW-1:0] prod;
        logic signed [WORD:0]    acc;
        logic                    res_signed;
        post_shr_e               shr;
        logic                    sat;
        logic                    zero;
        logic                    err;
    } mul_reg_t;
endpackage

// File: rtl/vmad_pick.sv
module vmad_pick
    import vmad_pkg::*;
(
    input  logic [WORD-1:0]       src,
    input  logic                  chunk,
    input  sub_sel_e              sel,
    input  logic [POSW-1:0]       pos,
    input  logic                  is_signed,
    output logic signed [OPW-1:0] val,
    output logic                  rsvd,
    output logic                  wide
);
    logic [WORD-1:0] shifted;
    logic [BYTE-1:0] byte_v;
    logic [HALF-1:0] half_v;

    always_comb begin
        shifted = src >> (pos * BYTE);
        byte_v  = shifted[BYTE-1:0];
        half_v  = '0;
        rsvd    = 1'b0;
        wide    = 1'b0;
        val     = '0;
        if (!chunk) begin
            val = {{(OPW-BYTE){is_signed & byte_v[BYTE-1]}}, byte_v};
        end else begin
            unique case (sel)
                SEL_LOW:  half_v = src[HALF-1:0];
                SEL_HIGH: half_v = src[WORD-1:HALF];
                SEL_WORD: wide   = 1'b1;
                SEL_RSVD: rsvd   = 1'b1;
            endcase
            val = {{(OPW-HALF){is_signed & half_v[HALF-1]}}, half_v};
        end
    end

    // R1: an unsigned byte never reaches past bit 7
    always_comb begin
        if (!chunk && !is_signed)
            a_r1_byte_unsigned_range: assert (val[OPW-1:BYTE] == '0)
                else $error("unsigned byte operand out of range");
    end
endmodule

// File: rtl/vmad_mul_stage.sv
module vmad_mul_stage
    import vmad_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  up_valid,
    output logic                  up_ready,
    input  logic signed [OPW-1:0] a_val,
    input  logic signed [OPW-1:0] b_val,
    input  logic signed [WORD:0]  acc_ext,
    input  logic                  res_signed,
    input  post_shr_e             shr,
    input  logic                  sat,
    input  logic                  zero,
    input  logic                  err,
    output logic                  dn_valid,
    input  logic                  dn_take,
    output mul_reg_t              dn_q
);
    stage_st_e st, st_nx;
    logic      accept;

    always_comb begin
        up_ready = (st == STG_EMPTY) || dn_take;
        accept   = up_valid && up_ready;
        dn_valid = (st == STG_FULL);
        st_nx    = st;
        unique case (st)
            STG_EMPTY: if (accept) st_nx = STG_FULL;
            STG_FULL:  if (dn_take && !accept) st_nx = STG_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= STG_EMPTY;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_q <= '0;
        end else if (accept) begin
            dn_q.prod       <= PRODW'(a_val) * PRODW'(b_val);
            dn_q.acc        <= acc_ext;
            dn_q.res_signed <= res_signed;
            dn_q.shr        <= shr;
            dn_q.sat        <= sat;
            dn_q.zero       <= zero;
            dn_q.err        <= err;
        end
    end

    // R11: a held product stays put until the next stage takes it
    a_r11_product_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == STG_FULL && !dn_take) |=> (st == STG_FULL && $stable(dn_q)));
endmodule

// File: rtl/vmad_finish_stage.sv
module vmad_finish_stage
    import vmad_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            up_valid,
    output logic            up_take,
    input  mul_reg_t        up_q,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [WORD-1:0] out_data,
    output logic            out_err
);
    localparam logic signed [SUMW-1:0] SMAX = {{(SUMW-WORD+1){1'b0}}, {(WORD-1){1'b1}}};
    localparam logic signed [SUMW-1:0] SMIN = {{(SUMW-WORD+1){1'b1}}, {(WORD-1){1'b0}}};
    localparam logic signed [SUMW-1:0] UMAX = {{(SUMW-WORD){1'b0}}, {WORD{1'b1}}};

    stage_st_e               st, st_nx;
    logic signed [SUMW-1:0]  sum, shifted, clamped;
    logic        [WORD-1:0]  res_nx;

    always_comb begin
        up_take   = up_valid && ((st == STG_EMPTY) || out_ready);
        out_valid = (st == STG_FULL);
        st_nx     = st;
        unique case (st)
            STG_EMPTY: if (up_take) st_nx = STG_FULL;
            STG_FULL:  if (out_ready && !up_take) st_nx = STG_EMPTY;
        endcase
    end

    always_comb begin
        sum = SUMW'(up_q.prod) + SUMW'(up_q.acc);
        unique case (up_q.shr)
            SHR_7:    shifted = sum >>> 7;
            SHR_15:   shifted = sum >>> 15;
            SHR_NONE,
            SHR_ALT:  shifted = sum;
        endcase
        clamped = shifted;
        if (up_q.sat) begin
            if (up_q.res_signed) begin
                if (shifted > SMAX)      clamped = SMAX;
                else if (shifted < SMIN) clamped = SMIN;
            end else begin
                if (shifted < 0)         clamped = '0;
                else if (shifted > UMAX) clamped = UMAX;
            end
        end
        res_nx = (up_q.zero || up_q.err) ? '0 : clamped[WORD-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= STG_EMPTY;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_err  <= 1'b0;
        end else if (up_take) begin
            out_data <= res_nx;
            out_err  <= up_q.err;
        end
    end

    // R3: a reserved selector yields a zero result without error
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (up_take && up_q.zero && !up_q.err) |=> (out_data == '0 && !out_err));
    // R4: the whole-word selector yields zero with the error flag
    a_r4_word_error: assert property (@(posedge clk) disable iff (!rst_n)
        (up_take && up_q.err) |=> (out_data == '0 && out_err));
endmodule

// File: rtl/subword_mac.sv
module subword_mac
    import vmad_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [31:0]     a_src,
    input  logic [31:0]     b_src,
    input  logic [31:0]     c_acc,
    input  logic [15:0]     imm_b,
    input  logic            a_signed,
    input  logic            b_signed,
    input  logic            a_chunk,
    input  logic [1:0]      a_type,
    input  logic [1:0]      a_pos,
    input  logic            b_chunk,
    input  logic [1:0]      b_type,
    input  logic [1:0]      b_pos,
    input  logic            b_from_reg,
    input  logic [1:0]      shift_sel,
    input  logic            saturate,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [31:0]     out_data,
    output logic            out_err
);
    logic signed [OPW-1:0] a_val, b_reg_val, b_val;
    logic                  a_rsvd, a_wide, b_rsvd, b_wide;
    logic                  res_signed, zero_f, err_f;
    logic signed [WORD:0]  acc_ext;
    logic                  s1_valid, s1_take;
    mul_reg_t              s1_q;

    vmad_pick u_pick_a (
        .src(a_src), .chunk(a_chunk), .sel(sub_sel_e'(a_type)), .pos(a_pos),
        .is_signed(a_signed), .val(a_val), .rsvd(a_rsvd), .wide(a_wide)
    );

    vmad_pick u_pick_b (
        .src(b_src), .chunk(b_chunk), .sel(sub_sel_e'(b_type)), .pos(b_pos),
        .is_signed(b_signed), .val(b_reg_val), .rsvd(b_rsvd), .wide(b_wide)
    );

    always_comb begin
        res_signed = a_signed || b_signed;
        b_val   = b_from_reg ? b_reg_val
                             : {b_signed & imm_b[HALF-1], imm_b};
        acc_ext = {res_signed & c_acc[WORD-1], c_acc};
        zero_f  = a_rsvd || (b_from_reg && b_rsvd);
        err_f   = a_wide || (b_from_reg && b_wide);
    end

    vmad_mul_stage u_mul (
        .clk(clk), .rst_n(rst_n),
        .up_valid(in_valid), .up_ready(in_ready),
        .a_val(a_val), .b_val(b_val), .acc_ext(acc_ext),
        .res_signed(res_signed), .shr(post_shr_e'(shift_sel)),
        .sat(saturate), .zero(zero_f), .err(err_f),
        .dn_valid(s1_valid), .dn_take(s1_take), .dn_q(s1_q)
    );

    vmad_finish_stage u_fin (
        .clk(clk), .rst_n(rst_n),
        .up_valid(s1_valid), .up_take(s1_take), .up_q(s1_q),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_err(out_err)
    );

    // R11: a refused result is held unchanged
    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));
    // R10: input is refused only under an output stall
    a_r10_ready_only_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready));
endmodule

// File: tb/test_subword_mac.sv
`timescale 1ns/1ps
module test_subword_mac;
    typedef struct packed {
        logic [31:0] a, b, c;
        logic [15:0] imm;
        logic as, bs, ac, bc, breg, sat;
        logic [1:0] at, ap, bt, bp, sh;
    } op_t;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_ready, out_valid, out_ready = 0, out_err;
    logic [31:0] a_src = 0, b_src = 0, c_acc = 0, out_data;
    logic [15:0] imm_b = 0;
    logic a_signed = 0, b_signed = 0, a_chunk = 0, b_chunk = 0, b_from_reg = 0, saturate = 0;
    logic [1:0] a_type = 0, a_pos = 0, b_type = 0, b_pos = 0, shift_sel = 0;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0, force_rdy = 1;
    logic [32:0] exp_q[$];
    string tag_q[$];
    int cyc_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    subword_mac i_subword_mac (.*);

    task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic longint pick(logic [31:0] s, logic ch, logic [1:0] t, logic [1:0] p, logic sg);
        longint v;
        if (!ch) begin
            v = longint'((s >> (8 * p)) & 32'hFF);
            if (sg && v >= 128) v = v - 256;
        end else begin
            if (t == 0)      v = longint'(s & 32'hFFFF);
            else if (t == 1) v = longint'(s >> 16);
            else             v = 0;
            if (sg && v >= 32768) v = v - 65536;
        end
        return v;
    endfunction

    function automatic logic [32:0] model(op_t o);
        logic e, z, rs;
        longint a, b, c, s;
        e  = (o.ac && o.at == 2) || (o.breg && o.bc && o.bt == 2);
        z  = (o.ac && o.at == 3) || (o.breg && o.bc && o.bt == 3);
        if (e || z) return {e, 32'h0};
        rs = o.as | o.bs;
        a  = pick(o.a, o.ac, o.at, o.ap, o.as);
        if (o.breg)    b = pick(o.b, o.bc, o.bt, o.bp, o.bs);
        else if (o.bs) b = longint'($signed(o.imm));
        else           b = longint'(o.imm);
        c  = rs ? longint'($signed(o.c)) : longint'(o.c);
        s  = a * b + c;
        if (o.sh == 1)      s = s >>> 7;
        else if (o.sh == 2) s = s >>> 15;
        if (o.sat) begin
            if (rs) begin
                if (s > 64'sd2147483647)  s = 64'sd2147483647;
                if (s < -64'sd2147483648) s = -64'sd2147483648;
            end else begin
                if (s < 0)                s = 0;
                if (s > 64'sd4294967295)  s = 64'sd4294967295;
            end
        end
        return {1'b0, s[31:0]};
    endfunction

    // driver: called just after a falling edge, returns at a falling edge
    task automatic send(string tag, op_t o);
        a_src = o.a; b_src = o.b; c_acc = o.c; imm_b = o.imm;
        a_signed = o.as; b_signed = o.bs; a_chunk = o.ac; b_chunk = o.bc;
        a_type = o.at; a_pos = o.ap; b_type = o.bt; b_pos = o.bp;
        b_from_reg = o.breg; shift_sel = o.sh; saturate = o.sat;
        in_valid = 1;
        #1;
        while (!in_ready) begin
            @(negedge clk); #1;
        end
        exp_q.push_back(model(o));
        tag_q.push_back(tag);
        cyc_q.push_back(cyc);
        @(negedge clk);
        in_valid = 0;
    endtask

    // monitor / scoreboard
    initial begin
        logic pv = 0, pr = 0, perr = 0;
        logic [31:0] pd = 0;
        forever begin
            @(negedge clk);
            out_ready = force_rdy ? 1'b1 : ($urandom_range(0, 2) != 0);
            if (rst_n && pv && !pr)
                check("R11 hold", {out_valid, out_err, out_data}, {1'b1, perr, pd});
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R10 extra result: actual %h expected none", out_data);
                end else begin
                    logic [32:0] e;
                    string t;
                    int c0;
                    e = exp_q.pop_front(); t = tag_q.pop_front(); c0 = cyc_q.pop_front();
                    check(t, {out_err, out_data}, e);
                    if (force_rdy)
                        check("R10 latency", 33'(cyc - c0), 33'd2);
                end
            end
            pv = out_valid; pr = out_ready; pd = out_data; perr = out_err;
        end
    end

    function automatic op_t base();
        op_t o;
        o = '0;
        o.breg = 1;
        return o;
    endfunction

    initial begin
        op_t o;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check("R12 reset", {31'b0, out_valid, in_ready}, 33'b01);
        rst_n = 1;
        @(negedge clk);
        check("R12 after release", {31'b0, out_valid, in_ready}, 33'b01);

        // R1: byte picks, unsigned and signed
        o = base(); o.a = 32'h11F45678; o.ap = 2; o.b = 32'h00000300; o.bp = 1; o.c = 10;
        send("R1 byte unsigned", o);
        o.as = 1; send("R1 byte signed", o);
        o.ap = 3; o.as = 0; o.bs = 1; o.b = 32'h80000000; o.bp = 3; send("R1 byte pos3", o);
        // R2: half picks
        o = base(); o.ac = 1; o.at = 1; o.a = 32'h8001_1234; o.bc = 1; o.bt = 0; o.b = 32'h0000_0005;
        send("R2 high unsigned", o);
        o.as = 1; send("R2 high signed", o);
        o.at = 0; o.a = 32'h0000_F000; send("R2 low signed", o);
        // R3: reserved selector
        o = base(); o.ac = 1; o.at = 3; o.a = 32'hFFFF; o.b = 7; o.c = 32'h1234; send("R3 a reserved", o);
        o = base(); o.bc = 1; o.bt = 3; o.a = 9; o.b = 32'h77; o.c = 32'h55; o.sat = 1; send("R3 b reserved", o);
        // R4: whole-word selector
        o = base(); o.ac = 1; o.at = 2; o.a = 3; o.b = 3; o.c = 1; send("R4 a word", o);
        o = base(); o.bc = 1; o.bt = 2; o.a = 3; o.b = 3; o.c = 1; send("R4 b word", o);
        // R5: immediate B, selector fields ignored
        o = base(); o.breg = 0; o.imm = 16'hFFFF; o.a = 5; o.c = 100; o.bs = 1; send("R5 imm signed", o);
        o.bs = 0; send("R5 imm unsigned", o);
        o.bc = 1; o.bt = 3; o.b = 32'hDEADBEEF; send("R5 ignored b fields", o);
        o.bt = 2; send("R5 ignored word sel", o);
        // R6: signedness of result and C
        o = base(); o.a = 32'hFF; o.b = 32'h02; o.c = 32'hFFFF_FFF0; send("R6 unsigned wrap c", o);
        o.bs = 1; send("R6 signed c", o);
        o.bs = 0; o.as = 1; send("R6 signed a", o);
        // R7: shifts
        o = base(); o.ac = 1; o.bc = 1; o.a = 32'h0000_7000; o.b = 32'h0000_1234; o.c = 32'h0001_0000;
        o.sh = 1; send("R7 shift 7", o);
        o.sh = 2; send("R7 shift 15", o);
        o.sh = 3; send("R7 code 3", o);
        o.as = 1; o.a = 32'h0000_9000; o.sh = 1; send("R7 arithmetic", o);
        // R8: saturation edges
        o = base(); o.ac = 1; o.bc = 1; o.as = 1; o.bs = 1; o.a = 32'h7FFF; o.b = 32'h7FFF;
        o.c = 32'h7FFF_FFFF; o.sat = 1; send("R8 signed high", o);
        o.a = 32'h8000; o.c = 32'h8000_0000; send("R8 signed low", o);
        o.as = 0; o.bs = 0; o.a = 32'hFFFF; o.b = 32'hFFFF; o.c = 32'hFFFF_FFFF; send("R8 unsigned high", o);
        o.c = 32'h0001_FFFF; send("R8 unsigned exact", o);
        // R9: wrap without saturation
        o.sat = 0; o.c = 32'hFFFF_FFFF; send("R9 unsigned wrap", o);
        o.as = 1; o.bs = 1; o.a = 32'h8000; o.b = 32'h7FFF; o.c = 32'h8000_0000; send("R9 signed wrap", o);
        repeat (4) @(negedge clk);

        // random phase with back-pressure
        force_rdy = 0;
        for (int i = 0; i < 800; i++) begin
            o = op_t'({$urandom, $urandom, $urandom, $urandom});
            if ($urandom_range(0, 9) != 0 && o.at >= 2) o.at = o.at - 2;
            if ($urandom_range(0, 9) != 0 && o.bt >= 2) o.bt = o.bt - 2;
            case ($urandom_range(0, 5))
                0: o.c = 32'h7FFF_FFFF;
                1: o.c = 32'h8000_0000;
                2: o.c = 32'hFFFF_FFFF;
                default: ;
            endcase
            if ($urandom_range(0, 3) == 0) begin o.a = 32'hFFFF_FFFF; o.b = 32'h7F7F_7F7F; end
            send("R6 random", o);
        end
        force_rdy = 1;
        repeat (10) @(negedge clk);
        check("R10 drained", 33'(exp_q.size()), 33'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule